// File: doc/BRIEF.md
# Keyed Watchdog with Software Reset

This block is a supervision timer that software must service by writing byte pairs to a single key register. Once enabled, a counter advances on every cycle in which the prescaler's tick is high. Unless software writes the restart pair before the counter reaches its limit, the block issues an internal reset pulse of fixed length. The limit is a power of two picked by a 3-bit period select. With the default parameters it ranges from 16K to 2048K counted ticks.

The key register also accepts a second pair that forces a software reset, whether or not the watchdog is enabled. Any other byte, or any mismatched pair, is treated as a fault and resets the chip at once. Two sticky cause flags record why the last internal reset happened: overflow and software. They survive the reset pulse and are cleared only by an explicit clear strobe or by the power-on reset input. The reset distribution network that consumes the pulse lies outside this block.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset (`rst_n` low), `rst_pulse`, `ovf_flag` and `sw_flag` are all 0.
- R2: While `wdt_en` is high, the count grows by one on each clock with `tick` high. A time-out fires on the 2^(BASE_LOG2+period_sel)-th such tick after the count was last zero. Any cycle with `wdt_en` low clears the count.
- R3: `period_sel` scales the time-out: with BASE_LOG2=4, the value 1 gives 32 ticks and the value 7 gives 2048 ticks.
- R4: Writing 0x1E and then 0xE1 to the key register restarts the count from zero. No reset and no flag change results.
- R5: Writing 0x5A and then 0xA5 starts a reset pulse and sets `sw_flag` only. This works with `wdt_en` low.
- R6: A first byte that is neither 0x1E nor 0x5A starts a reset pulse and sets both flags, and so does a second byte that does not complete the pair its first byte opened (0x1E then 0xA5, or 0x5A then 0xE1).
- R7: The reset pulse stays high for exactly PULSE_LEN (16) clocks. While it is high, key writes are ignored and the count is held at zero. A half-written pair is discarded when the pulse starts.
- R8: A time-out starts a reset pulse and sets `ovf_flag` only.
- R9: Both flags keep their value through the reset pulse. A `flag_clr` strobe clears them. If a set event arrives in the same cycle as `flag_clr`, the set wins.
- R10: Idle cycles between the two bytes of a pair do not break the pair. The pair is formed by consecutive key writes.
- R11: Cycles with `tick` low neither advance the count nor cause a time-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | Prescaled count enable |
| wdt_en | input | 1 | Watchdog enable. Low holds the count at zero |
| period_sel | input | 3 | Time-out select, limit = 2^(BASE_LOG2+period_sel) |
| key_wr | input | 1 | Write strobe for the key register |
| key_data | input | 8 | Byte written to the key register |
| flag_clr | input | 1 | Clears both cause flags |
| ovf_flag | output | 1 | Sticky overflow/fault cause flag |
| sw_flag | output | 1 | Sticky software/fault cause flag |
| rst_pulse | output | 1 | Internal reset pulse, PULSE_LEN clocks long |

## Verification
The hardest state to reach from the ports is a pair left half written at the moment the reset pulse begins. The pulse should discard it, so a later completing byte reads as a fault. The bench reaches this state by enabling the shortest period and writing the first restart byte on the last tick before the limit, so the time-out lands one clock later. After the pulse it writes the second byte alone and expects both flags. Key writes made in the middle of a pulse are checked in a similar way, by the remaining pulse length and the unchanged flags.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam logic [7:0] RESTART_KEY_LO = 8'h1E;
  localparam logic [7:0] RESTART_KEY_HI = 8'hE1;
  localparam logic [7:0] FORCE_KEY_LO   = 8'h5A;
  localparam logic [7:0] FORCE_KEY_HI   = 8'hA5;

  // Which pair, if any, the previous key write opened
  typedef enum logic [1:0] {
    ARM_NONE  = 2'd0,
    ARM_FEED  = 2'd1,
    ARM_FORCE = 2'd2
  } arm_t;

  typedef struct packed {
    logic feed;
    logic force_rst;
    logic fault;
  } key_evt_t;

  // Pair opened by a first byte (ARM_NONE means the byte is not a key)
  function automatic arm_t arm_of(input logic [7:0] b);
    if (b == RESTART_KEY_LO)    return ARM_FEED;
    else if (b == FORCE_KEY_LO) return ARM_FORCE;
    else                        return ARM_NONE;
  endfunction

  // Outcome of one accepted key write given the pair state
  function automatic key_evt_t judge(input arm_t arm, input logic [7:0] b);
    key_evt_t e;
    e = '0;
    case (arm)
      ARM_NONE:  e.fault = (arm_of(b) == ARM_NONE);
      ARM_FEED:  if (b == RESTART_KEY_HI) e.feed = 1'b1; else e.fault = 1'b1;
      ARM_FORCE: if (b == FORCE_KEY_HI) e.force_rst = 1'b1; else e.fault = 1'b1;
      default:   e.fault = 1'b1;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blocked,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       feed_evt,
  output logic       force_evt,
  output logic       fault_evt
);

  arm_t     arm_q;
  key_evt_t evt;

  always_comb begin
    evt = '0;
    if (key_wr && !blocked) evt = judge(arm_q, key_data);
  end

  assign feed_evt  = evt.feed;
  assign force_evt = evt.force_rst;
  assign fault_evt = evt.fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     arm_q <= ARM_NONE;
    else if (blocked)               arm_q <= ARM_NONE;
    else if (key_wr) begin
      if (arm_q == ARM_NONE)        arm_q <= arm_of(key_data);
      else                          arm_q <= ARM_NONE;
    end
  end

  // R6
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({feed_evt, force_evt, fault_evt}));

  // R7
  pulse_drops_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> (arm_q == ARM_NONE));

  // R10
  idle_keeps_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_wr && !blocked) |=> $stable(arm_q));

endmodule

// File: rtl/kwd_tmo_counter.sv
module kwd_tmo_counter #(
  parameter int BASE_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       hold,
  input  logic       restart,
  input  logic [2:0] period_sel,
  output logic       timeout_evt
);

  localparam int CW = BASE_LOG2 + 7;

  logic [CW-1:0] count_q;

  // Last count value before the time-out: 2^(BASE_LOG2+sel) - 1
  function automatic logic [CW-1:0] last_count(input logic [2:0] sel);
    return {CW{1'b1}} >> (3'd7 - sel);
  endfunction

  logic run;
  assign run         = enable && !hold && !restart;
  assign timeout_evt = run && tick && (count_q >= last_count(period_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count_q <= '0;
    else if (!run)        count_q <= '0;
    else if (timeout_evt) count_q <= '0;
    else if (tick)        count_q <= count_q + 1'b1;
  end

  // R2
  tmo_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (count_q == '0));

  // R2
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count_q == '0));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(count_q));

  // R7
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !timeout_evt);

endmodule

// File: rtl/kwd_pulse_gen.sv
module kwd_pulse_gen #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic active
);

  localparam int CNTW = $clog2(PULSE_LEN + 1);
  localparam logic [CNTW-1:0] LOAD = CNTW'(PULSE_LEN);

  logic [CNTW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (trigger)        left_q <= LOAD;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);

  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> active);

  // R7
  pulse_sustain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && left_q > 1) |=> active);

endmodule

// File: rtl/kwd_cause_flags.sv
module kwd_cause_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ovf,
  input  logic set_sw,
  input  logic clr,
  output logic ovf_flag,
  output logic sw_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      sw_flag  <= 1'b0;
    end else begin
      if (set_ovf)  ovf_flag <= 1'b1;
      else if (clr) ovf_flag <= 1'b0;
      if (set_sw)   sw_flag  <= 1'b1;
      else if (clr) sw_flag  <= 1'b0;
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ovf || set_sw) |=> ((ovf_flag || !$past(set_ovf)) && (sw_flag || !$past(set_sw))));

  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set_ovf && !set_sw) |=> ($stable(ovf_flag) && $stable(sw_flag)));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int BASE_LOG2 = 14,
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wdt_en,
  input  logic [2:0] period_sel,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       flag_clr,
  output logic       ovf_flag,
  output logic       sw_flag,
  output logic       rst_pulse
);

  logic feed_evt;
  logic force_evt;
  logic fault_evt;
  logic timeout_evt;
  logic trigger;

  kwd_key_seq u_keys (
    .clk       (clk),
    .rst_n     (rst_n),
    .blocked   (rst_pulse),
    .key_wr    (key_wr),
    .key_data  (key_data),
    .feed_evt  (feed_evt),
    .force_evt (force_evt),
    .fault_evt (fault_evt)
  );

  kwd_tmo_counter #(.BASE_LOG2(BASE_LOG2)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (wdt_en),
    .tick        (tick),
    .hold        (rst_pulse),
    .restart     (feed_evt),
    .period_sel  (period_sel),
    .timeout_evt (timeout_evt)
  );

  assign trigger = timeout_evt || force_evt || fault_evt;

  kwd_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (trigger),
    .active  (rst_pulse)
  );

  kwd_cause_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ovf  (timeout_evt || fault_evt),
    .set_sw   (force_evt || fault_evt),
    .clr      (flag_clr),
    .ovf_flag (ovf_flag),
    .sw_flag  (sw_flag)
  );

  // R7
  trigger_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> rst_pulse);

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(timeout_evt || fault_evt));

  // R5
  sw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_flag) |-> $past(force_evt || fault_evt));

  // R4
  feed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_evt |-> !trigger);

endmodule

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wdt_en = 1'b0;
  logic [2:0] period_sel = 3'd0;
  logic       key_wr = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic       flag_clr = 1'b0;
  logic       ovf_flag, sw_flag, rst_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_watchdog #(.BASE_LOG2(4), .PULSE_LEN(16)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wdt_en(wdt_en),
    .period_sel(period_sel), .key_wr(key_wr), .key_data(key_data),
    .flag_clr(flag_clr), .ovf_flag(ovf_flag), .sw_flag(sw_flag),
    .rst_pulse(rst_pulse)
  );

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic p, input logic o, input logic s);
    check_int(req, "rst_pulse", int'(rst_pulse), int'(p));
    check_int(req, "ovf_flag", int'(ovf_flag), int'(o));
    check_int(req, "sw_flag", int'(sw_flag), int'(s));
  endtask

  // All helpers start and end on a falling edge
  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_key(input logic [7:0] b);
    key_wr = 1'b1; key_data = b;
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic measure_pulse(output int n);
    n = 0;
    while (rst_pulse) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic start_wdt(input logic [2:0] sel, input logic t);
    wdt_en = 1'b0; period_sel = sel; tick = t;
    @(negedge clk);
    wdt_en = 1'b1;
  endtask

  task automatic settle();
    int n;
    measure_pulse(n);
    wdt_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check_state("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_timeout();
    int n;
    clear_flags();
    start_wdt(3'd0, 1'b1);
    run(15);
    check_int("R2", "no pulse before limit", int'(rst_pulse), 0);
    run(1);
    check_state("R8", 1'b1, 1'b1, 1'b0);
    measure_pulse(n);
    check_int("R7", "pulse length", n, 16);
    wdt_en = 1'b0; @(negedge clk);
  endtask

  task automatic t_period();
    start_wdt(3'd1, 1'b1);
    run(31);
    check_int("R3", "sel1 before limit", int'(rst_pulse), 0);
    run(1);
    check_int("R3", "sel1 at limit", int'(rst_pulse), 1);
    settle();
    start_wdt(3'd7, 1'b1);
    run(2047);
    check_int("R3", "sel7 before limit", int'(rst_pulse), 0);
    run(1);
    check_int("R3", "sel7 at limit", int'(rst_pulse), 1);
    settle();
  endtask

  task automatic t_feed();
    clear_flags();
    start_wdt(3'd0, 1'b1);
    run(5);
    wr_key(8'h1E);
    run(3);                       // R10: idle gap inside the pair
    wr_key(8'hE1);
    check_state("R4", 1'b0, 1'b0, 1'b0);
    run(15);
    check_int("R10", "fed count not expired", int'(rst_pulse), 0);
    run(1);
    check_int("R4", "expires 16 after feed", int'(rst_pulse), 1);
    settle();
  endtask

  task automatic t_tick();
    start_wdt(3'd0, 1'b0);
    run(40);
    check_int("R11", "no tick no timeout", int'(rst_pulse), 0);
    tick = 1'b1;
    run(15);
    check_int("R11", "ticks before limit", int'(rst_pulse), 0);
    run(1);
    check_int("R11", "limit after ticks", int'(rst_pulse), 1);
    settle();
  endtask

  task automatic t_disable();
    start_wdt(3'd0, 1'b1);
    run(10);
    wdt_en = 1'b0;
    @(negedge clk);
    wdt_en = 1'b1;
    run(15);
    check_int("R2", "disable cleared count", int'(rst_pulse), 0);
    run(1);
    check_int("R2", "full period after re-enable", int'(rst_pulse), 1);
    settle();
  endtask

  task automatic t_soft();
    int n;
    wdt_en = 1'b0;
    clear_flags();
    wr_key(8'h5A);
    run(4);
    wr_key(8'hA5);
    check_state("R5", 1'b1, 1'b0, 1'b1);
    measure_pulse(n);
    check_int("R5", "soft pulse length", n, 16);
  endtask

  task automatic t_bad();
    clear_flags();
    wr_key(8'h33);
    check_state("R6", 1'b1, 1'b1, 1'b1);
    settle();
    clear_flags();
    wr_key(8'h1E);
    check_int("R6", "half pair no pulse", int'(rst_pulse), 0);
    wr_key(8'hA5);
    check_state("R6", 1'b1, 1'b1, 1'b1);
    settle();
    clear_flags();
    wr_key(8'h5A);
    wr_key(8'hE1);
    check_state("R6", 1'b1, 1'b1, 1'b1);
    settle();
  endtask

  task automatic t_block();
    int n;
    clear_flags();
    wr_key(8'h5A);
    wr_key(8'hA5);
    run(2);
    wr_key(8'h33);
    measure_pulse(n);
    check_int("R7", "pulse not extended by write", n, 13);
    check_int("R7", "write ignored in pulse", int'(ovf_flag), 0);
    check_int("R9", "sw flag survives pulse", int'(sw_flag), 1);
  endtask

  task automatic t_pending_dropped();
    start_wdt(3'd0, 1'b1);
    run(14);
    wr_key(8'h1E);
    run(1);
    check_int("R7", "timeout after half pair", int'(rst_pulse), 1);
    settle();
    clear_flags();
    wr_key(8'hE1);
    check_state("R7", 1'b1, 1'b1, 1'b1);
    settle();
  endtask

  task automatic t_flags();
    check_state("R9", 1'b0, 1'b1, 1'b1);
    clear_flags();
    check_state("R9", 1'b0, 1'b0, 1'b0);
    flag_clr = 1'b1;
    wr_key(8'h33);
    flag_clr = 1'b0;
    check_state("R9", 1'b1, 1'b1, 1'b1);
    settle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    run(1);
    t_reset();
    t_timeout();
    t_period();
    t_feed();
    t_tick();
    t_disable();
    t_soft();
    t_bad();
    t_block();
    t_pending_dropped();
    t_flags();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule